// File: doc/BRIEF.md
# Channel-Sliced Stream Demultiplexer

This block takes a single valid/ready stream that carries a channel number with every beat and steers each beat to one of `N_PORTS` identical output streams. A fixed slice of the incoming channel field picks the destination port. A parameter decides whether that slice is the most significant or the least significant `SEL_W` bits, where `SEL_W = clog2(N_PORTS)`, or 1 when `N_PORTS` is 2. The channel bits left over after the slice is removed go to the chosen port as its output channel.

Payload, error bits and the optional packet sideband (start-of-packet, end-of-packet, empty count) reach the output in the same cycle, with no register anywhere on the path. Backpressure from the addressed port goes straight back to the input. The block stores nothing, so beats leave in the order they arrive whatever their channel or packet markers are. With a power-of-two port count every selector value names a real port. With any other count, a beat whose selector is at or above `N_PORTS` is accepted and discarded.

The block holds no state at all: there is no state register, no state and no transition. Every output is a combinational function of the present inputs.

Top module: `stream_chan_demux`

## Requirements
- R1: With `SEL_HIGH=0`, the destination port is the value of the low `SEL_W` bits of `in_chan`, and that port's output channel is `in_chan >> SEL_W` (width `CHAN_W-SEL_W`). With 2 ports, even channels go to port 0 and odd channels to port 1.
- R2: With `SEL_HIGH=1`, the destination port is the value of the top `SEL_W` bits of `in_chan`, and the output channel is the low `CHAN_W-SEL_W` bits. With a 5-bit channel and 2 ports, channels 0 to 15 go to port 0 and channels 16 to 31 go to port 1, each carrying a 4-bit channel.
- R3: At most one bit of `out_valid` is high in any cycle, and it is the bit of the destination port. Port k uses bit k of every per-port vector and bits `[k*W +: W]` of every packed per-port bus.
- R4: When the destination port exists, `in_ready` equals that port's `out_ready` bit, whatever the `out_ready` bits of the other ports are.
- R5: On the destination port, the data, error, start, end and empty fields equal the input fields in the same cycle.
- R6: A beat whose selector is `N_PORTS` or above raises no `out_valid` and sees `in_ready` high, so it is consumed and dropped.
- R7: While `in_valid` is low, every `out_valid` bit is low.
- R8: With `HAS_PKT=0`, `out_sop`, `out_eop` and `out_empty` stay zero on every port, even when the matching input fields are set.
- R9: An output handshake (valid and ready high on the same port) happens only in a cycle where the input handshake also happens. This gives zero latency and keeps arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Input beat may be taken |
| in_data | input | DATA_W | Input payload |
| in_chan | input | CHAN_W | Input channel, including the port selector |
| in_err | input | ERR_W | Input error bits |
| in_sop | input | 1 | Input start of packet |
| in_eop | input | 1 | Input end of packet |
| in_empty | input | EMPTY_W | Count of unused symbols in the beat |
| out_valid | output | N_PORTS | Per-port beat present |
| out_ready | input | N_PORTS | Per-port ready |
| out_data | output | N_PORTS*DATA_W | Per-port payload |
| out_chan | output | N_PORTS*(CHAN_W-SEL_W) | Per-port remaining channel |
| out_err | output | N_PORTS*ERR_W | Per-port error bits |
| out_sop | output | N_PORTS | Per-port start of packet |
| out_eop | output | N_PORTS | Per-port end of packet |
| out_empty | output | N_PORTS*EMPTY_W | Per-port empty count |

## Verification
There is no stored state, so a wrong slice, a wrong decode or a wrong ready mux shows at the ports in the same cycle as the stimulus. It appears as a valid raised on the wrong port, a stray channel value, or `in_ready` following the wrong port. The sweep walks every channel value against every ready pattern on three small configurations: high slice with a non-power-of-two count, low slice, and the 5-bit high-slice case. A single wrong bit in any mapping therefore shows up at one specific channel value.

// File: rtl/stream_chan_demux_pkg.sv
package stream_chan_demux_pkg;
    function automatic int unsigned sel_bits(input int unsigned ports);
        return (ports <= 2) ? 1 : $clog2(ports);
    endfunction
endpackage

// File: rtl/stream_chan_demux_split.sv
module stream_chan_demux_split #(
    parameter int CHAN_W   = 6,
    parameter int SEL_W    = 2,
    parameter bit SEL_HIGH = 1'b1
) (
    input  logic [CHAN_W-1:0]       chan,
    output logic [SEL_W-1:0]        sel,
    output logic [CHAN_W-SEL_W-1:0] rest
);
    localparam int REST_W = CHAN_W - SEL_W;

    generate
        if (SEL_HIGH) begin : g_high
            assign sel  = chan[CHAN_W-1 -: SEL_W];
            assign rest = chan[REST_W-1:0];
        end else begin : g_low
            assign sel  = chan[SEL_W-1:0];
            assign rest = chan[CHAN_W-1:SEL_W];
        end
    endgenerate
endmodule

// File: rtl/stream_chan_demux_decode.sv
module stream_chan_demux_decode #(
    parameter int N_PORTS = 4,
    parameter int SEL_W   = 2
) (
    input  logic               in_valid,
    input  logic [SEL_W-1:0]   sel,
    input  logic [N_PORTS-1:0] out_ready,
    output logic [N_PORTS-1:0] out_valid,
    output logic               in_ready
);
    always_comb begin
        out_valid = '0;
        in_ready  = 1'b1;
        for (int p = 0; p < N_PORTS; p++) begin
            if (int'(sel) == p) begin
                out_valid[p] = in_valid;
                in_ready     = out_ready[p];
            end
        end
    end
endmodule

// File: rtl/stream_chan_demux_fanout.sv
module stream_chan_demux_fanout #(
    parameter int N_PORTS = 4,
    parameter int DATA_W  = 32,
    parameter int REST_W  = 4,
    parameter int ERR_W   = 1,
    parameter int EMPTY_W = 2,
    parameter bit HAS_PKT = 1'b1
) (
    input  logic [DATA_W-1:0]          data,
    input  logic [REST_W-1:0]          rest,
    input  logic [ERR_W-1:0]           err,
    input  logic                       sop,
    input  logic                       eop,
    input  logic [EMPTY_W-1:0]         empty,
    output logic [N_PORTS*DATA_W-1:0]  o_data,
    output logic [N_PORTS*REST_W-1:0]  o_chan,
    output logic [N_PORTS*ERR_W-1:0]   o_err,
    output logic [N_PORTS-1:0]         o_sop,
    output logic [N_PORTS-1:0]         o_eop,
    output logic [N_PORTS*EMPTY_W-1:0] o_empty
);
    generate
        for (genvar p = 0; p < N_PORTS; p++) begin : g_port
            assign o_data[p*DATA_W +: DATA_W] = data;
            assign o_chan[p*REST_W +: REST_W] = rest;
            assign o_err[p*ERR_W +: ERR_W]    = err;
            if (HAS_PKT) begin : g_pkt
                assign o_sop[p]                     = sop;
                assign o_eop[p]                     = eop;
                assign o_empty[p*EMPTY_W +: EMPTY_W] = empty;
            end else begin : g_nopkt
                assign o_sop[p]                     = 1'b0;
                assign o_eop[p]                     = 1'b0;
                assign o_empty[p*EMPTY_W +: EMPTY_W] = '0;
            end
        end
    endgenerate
endmodule

// File: rtl/stream_chan_demux.sv
module stream_chan_demux
    import stream_chan_demux_pkg::*;
#(
    parameter int N_PORTS  = 4,
    parameter int DATA_W   = 32,
    parameter int CHAN_W   = 6,
    parameter int ERR_W    = 1,
    parameter int EMPTY_W  = 2,
    parameter bit SEL_HIGH = 1'b1,
    parameter bit HAS_PKT  = 1'b1,
    localparam int SEL_W   = sel_bits(N_PORTS),
    localparam int REST_W  = CHAN_W - SEL_W
) (
    input  logic                       in_valid,
    output logic                       in_ready,
    input  logic [DATA_W-1:0]          in_data,
    input  logic [CHAN_W-1:0]          in_chan,
    input  logic [ERR_W-1:0]           in_err,
    input  logic                       in_sop,
    input  logic                       in_eop,
    input  logic [EMPTY_W-1:0]         in_empty,
    output logic [N_PORTS-1:0]         out_valid,
    input  logic [N_PORTS-1:0]         out_ready,
    output logic [N_PORTS*DATA_W-1:0]  out_data,
    output logic [N_PORTS*REST_W-1:0]  out_chan,
    output logic [N_PORTS*ERR_W-1:0]   out_err,
    output logic [N_PORTS-1:0]         out_sop,
    output logic [N_PORTS-1:0]         out_eop,
    output logic [N_PORTS*EMPTY_W-1:0] out_empty
);
    logic [SEL_W-1:0]  port_sel;
    logic [REST_W-1:0] chan_rest;

    stream_chan_demux_split #(
        .CHAN_W(CHAN_W), .SEL_W(SEL_W), .SEL_HIGH(SEL_HIGH)
    ) u_split (
        .chan(in_chan), .sel(port_sel), .rest(chan_rest)
    );

    stream_chan_demux_decode #(
        .N_PORTS(N_PORTS), .SEL_W(SEL_W)
    ) u_decode (
        .in_valid(in_valid), .sel(port_sel), .out_ready(out_ready),
        .out_valid(out_valid), .in_ready(in_ready)
    );

    stream_chan_demux_fanout #(
        .N_PORTS(N_PORTS), .DATA_W(DATA_W), .REST_W(REST_W),
        .ERR_W(ERR_W), .EMPTY_W(EMPTY_W), .HAS_PKT(HAS_PKT)
    ) u_fanout (
        .data(in_data), .rest(chan_rest), .err(in_err), .sop(in_sop),
        .eop(in_eop), .empty(in_empty), .o_data(out_data), .o_chan(out_chan),
        .o_err(out_err), .o_sop(out_sop), .o_eop(out_eop), .o_empty(out_empty)
    );
endmodule

// File: rtl/stream_chan_demux_chk.sv
module stream_chan_demux_chk #(
    parameter int N_PORTS = 4,
    parameter int DATA_W  = 32
) (
    input logic                      in_valid,
    input logic                      in_ready,
    input logic [DATA_W-1:0]         in_data,
    input logic [N_PORTS-1:0]        out_valid,
    input logic [N_PORTS-1:0]        out_ready,
    input logic [N_PORTS*DATA_W-1:0] out_data
);
    always_comb begin
        assert_onehot_valid_R3: assert ($onehot0(out_valid));
        if (!in_valid) begin
            assert_idle_when_empty_R7: assert (out_valid == '0);
        end
        if (in_valid && out_valid == '0) begin
            assert_drop_consumes_R6: assert (in_ready);
        end
        if (|(out_valid & out_ready)) begin
            assert_handshake_same_cycle_R9: assert (in_valid && in_ready);
        end
        for (int k = 0; k < N_PORTS; k++) begin
            if (out_valid[k]) begin
                assert_ready_follows_port_R4: assert (in_ready == out_ready[k]);
                assert_payload_passes_R5: assert (out_data[k*DATA_W +: DATA_W] == in_data);
            end
        end
    end
endmodule

bind stream_chan_demux stream_chan_demux_chk #(
    .N_PORTS(N_PORTS), .DATA_W(DATA_W)
) u_chk (
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
);

// File: tb/stream_chan_demux_bench.sv
`timescale 1ns/1ps
module stream_chan_demux_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic       in_valid;
    logic [7:0] in_data;
    logic [4:0] in_chan5;
    logic [1:0] in_err;
    logic       in_sop, in_eop;
    logic       in_empty;

    // A: 3 ports, high slice, 4-bit channel
    logic       a_rdy_in;
    logic [2:0] a_valid, a_ready, a_sop, a_eop, a_empty;
    logic [23:0] a_data;
    logic [5:0] a_chan, a_err;
    // B: 2 ports, low slice, 4-bit channel, no packet sideband
    logic       b_rdy_in;
    logic [1:0] b_valid, b_ready, b_sop, b_eop, b_empty;
    logic [15:0] b_data;
    logic [5:0] b_chan;
    logic [3:0] b_err;
    // C: 2 ports, high slice, 5-bit channel
    logic       c_rdy_in;
    logic [1:0] c_valid, c_ready, c_sop, c_eop, c_empty;
    logic [15:0] c_data;
    logic [7:0] c_chan;
    logic [3:0] c_err;

    stream_chan_demux #(.N_PORTS(3), .DATA_W(8), .CHAN_W(4), .ERR_W(2), .EMPTY_W(1),
        .SEL_HIGH(1'b1), .HAS_PKT(1'b1)) u_stream_chan_demux (
        .in_valid(in_valid), .in_ready(a_rdy_in), .in_data(in_data), .in_chan(in_chan5[3:0]),
        .in_err(in_err), .in_sop(in_sop), .in_eop(in_eop), .in_empty(in_empty),
        .out_valid(a_valid), .out_ready(a_ready), .out_data(a_data), .out_chan(a_chan),
        .out_err(a_err), .out_sop(a_sop), .out_eop(a_eop), .out_empty(a_empty));

    stream_chan_demux #(.N_PORTS(2), .DATA_W(8), .CHAN_W(4), .ERR_W(2), .EMPTY_W(1),
        .SEL_HIGH(1'b0), .HAS_PKT(1'b0)) u_stream_chan_demux_low (
        .in_valid(in_valid), .in_ready(b_rdy_in), .in_data(in_data), .in_chan(in_chan5[3:0]),
        .in_err(in_err), .in_sop(in_sop), .in_eop(in_eop), .in_empty(in_empty),
        .out_valid(b_valid), .out_ready(b_ready), .out_data(b_data), .out_chan(b_chan),
        .out_err(b_err), .out_sop(b_sop), .out_eop(b_eop), .out_empty(b_empty));

    stream_chan_demux #(.N_PORTS(2), .DATA_W(8), .CHAN_W(5), .ERR_W(2), .EMPTY_W(1),
        .SEL_HIGH(1'b1), .HAS_PKT(1'b1)) u_stream_chan_demux_wide (
        .in_valid(in_valid), .in_ready(c_rdy_in), .in_data(in_data), .in_chan(in_chan5),
        .in_err(in_err), .in_sop(in_sop), .in_eop(in_eop), .in_empty(in_empty),
        .out_valid(c_valid), .out_ready(c_ready), .out_data(c_data), .out_chan(c_chan),
        .out_err(c_err), .out_sop(c_sop), .out_eop(c_eop), .out_empty(c_empty));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input int c, input int r);
        @(negedge clk);
        in_valid = 1'b1;
        in_chan5 = 5'(c);
        in_data  = 8'(c * 37 + r * 5 + 11);
        in_err   = 2'(c + r);
        in_sop   = 1'b1;
        in_eop   = c[0];
        in_empty = ~c[1];
        a_ready  = 3'(r);
        b_ready  = 2'(r);
        c_ready  = 2'(r);
        #1;
    endtask

    initial begin
        in_valid = 1'b0; in_chan5 = '0; in_data = '0; in_err = '0;
        in_sop = 1'b0; in_eop = 1'b0; in_empty = 1'b0;
        a_ready = '1; b_ready = '1; c_ready = '1;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk); #1;
        check("R7 idle A", 32'(a_valid), 0);
        check("R7 idle B", 32'(b_valid), 0);
        check("R7 idle C", 32'(c_valid), 0);

        // A sweep: high slice, 3 ports, selector 3 is dropped
        for (int c = 0; c < 16; c++) begin
            for (int r = 0; r < 8; r++) begin
                int s;
                drive(c, r);
                s = c >> 2;
                if (s < 3) begin
                    check("R2 R3 A valid", 32'(a_valid), 32'(1 << s));
                    check("R4 A ready", 32'(a_rdy_in), 32'((r >> s) & 1));
                    check("R2 A chan", 32'(a_chan[s*2 +: 2]), 32'(c & 3));
                    check("R5 A data", 32'(a_data[s*8 +: 8]), 32'(in_data));
                    check("R5 A err", 32'(a_err[s*2 +: 2]), 32'(in_err));
                    check("R5 A sop", 32'(a_sop[s]), 1);
                    check("R5 A eop", 32'(a_eop[s]), 32'(c & 1));
                    check("R5 A empty", 32'(a_empty[s]), 32'(((c >> 1) & 1) ^ 1));
                    check("R9 A xfer", 32'(|(a_valid & a_ready)), 32'((r >> s) & 1));
                end else begin
                    check("R6 A drop valid", 32'(a_valid), 0);
                    check("R6 A drop ready", 32'(a_rdy_in), 1);
                end
                in_valid = 1'b0; #1;
                check("R7 A no valid", 32'(a_valid), 0);
            end
        end

        // B sweep: low slice, even/odd split, packet fields held low
        for (int c = 0; c < 16; c++) begin
            for (int r = 0; r < 4; r++) begin
                int s;
                drive(c, r);
                s = c & 1;
                check("R1 R3 B valid", 32'(b_valid), 32'(1 << s));
                check("R4 B ready", 32'(b_rdy_in), 32'((r >> s) & 1));
                check("R1 B chan", 32'(b_chan[s*3 +: 3]), 32'(c >> 1));
                check("R5 B data", 32'(b_data[s*8 +: 8]), 32'(in_data));
                check("R8 B sop", 32'(b_sop), 0);
                check("R8 B eop", 32'(b_eop), 0);
                check("R8 B empty", 32'(b_empty), 0);
            end
        end

        // C sweep: 5-bit channel, 0..15 -> port 0, 16..31 -> port 1
        for (int c = 0; c < 32; c++) begin
            for (int r = 0; r < 4; r++) begin
                int s;
                drive(c, r);
                s = (c >= 16) ? 1 : 0;
                check("R2 R3 C valid", 32'(c_valid), 32'(1 << s));
                check("R4 C ready", 32'(c_rdy_in), 32'((r >> s) & 1));
                check("R2 C chan", 32'(c_chan[s*4 +: 4]), 32'(c & 15));
                check("R5 C data", 32'(c_data[s*8 +: 8]), 32'(in_data));
                check("R9 C xfer", 32'(|(c_valid & c_ready)), 32'((r >> s) & 1));
            end
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule